// File: doc/BRIEF.md
# FIFO-Buffered Pulse-Width Modulator

The block produces a single pulse-width modulated output. Its period is set in a period register. Each period's high time comes from a duty sample. Software writes duty samples into a small queue ahead of time. The generator takes one queued sample at the start of every period. This lets a stream of duty values play out period by period without software having to keep pace with the waveform. When the queue runs dry, the last sample in use is repeated.

A programmable prescaler divides the block clock into counter ticks. A status word reports how many samples are queued and whether a write was lost. A self-clearing soft-reset bit empties the queue and returns every register to zero. Access is through a plain synchronous register port: address, write strobe, write word and a combinational read word.

Top module: `fifo_pwm`

## Requirements
- R1: After the reset input is released, every register reads zero and `pwm_o` is low.
- R2: The sample queue holds 4 entries. Bits [2:0] of the status word at address 0x04 give the number of queued samples, and 4 means the queue is full.
- R3: A write to address 0x0C while the queue is full, with no slot freed in the same cycle, is dropped. It sets the sticky lost-write flag at status bit 4. Writing 1 to status bit 4 clears the flag; writing 0 leaves it set.
- R4: One period lasts the value of the period register (address 0x10, 16 bits) plus 2 counter ticks. One counter tick is (control bits [15:4] + 1) clocks.
- R5: `pwm_o` is high from the start of a period for as many ticks as the active sample, then low until the period ends. A sample of 0 gives a low period, and a sample of at least the period length gives a high period.
- R6: At each period start while enabled, the oldest queued sample becomes active and its slot is released. If the queue is empty, the previous active sample is reused. Address 0x0C reads back the active sample.
- R7: While control bit 0 is 0, the counter and prescaler are held, `pwm_o` stays low and the queue is not consumed. Enabling starts the first period on the first counter tick.
- R8: Writing control (address 0x00) with bit 3 set starts a soft reset. Bit 3 reads 1 for 4 clocks, then reads 0. The queue, the lost-write flag and all registers are cleared, and every register write during those 4 clocks is ignored.
- R9: Control bits [17:16] hold a clock-source code that reads back unchanged and has no effect on the waveform.
- R10: A sample write in the same cycle as a period start that takes a sample from a full queue is accepted. The queue stays full and the lost-write flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte address |
| reg_we | input | 1 | Write strobe, one write per clock |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word for `reg_addr`, combinational |
| pwm_o | output | 1 | Modulated output |

## Verification
A sample push and a period-start pop can fall in the same clock edge. When the queue is full, this decides whether the write survives. The bench fills the queue while the block is disabled and sets a long period. It then places a sample write on the edge right after the enable write, which is the edge where the first period starts. A correct result shows four entries, a clear lost-write flag and the pushed value appearing later as the active sample. A second write one edge later must be dropped and must raise the flag.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int FPWM_A_CTRL   = 'h00;
  localparam int FPWM_A_STAT   = 'h04;
  localparam int FPWM_A_SAMPLE = 'h0C;
  localparam int FPWM_A_PERIOD = 'h10;

  localparam int FPWM_EN_BIT   = 0;
  localparam int FPWM_SWR_BIT  = 3;
  localparam int FPWM_PRE_LSB  = 4;
  localparam int FPWM_CLK_LSB  = 16;
  localparam int FPWM_CLK_W    = 2;
  localparam int FPWM_OVF_BIT  = 4;

  // index of the final tick in a period: period value + 1 (period is +2 ticks long)
  function automatic logic [31:0] fpwm_last_tick(input logic [31:0] per);
    return per + 32'd1;
  endfunction

  // output level at counter position pos for an active sample smp
  function automatic logic fpwm_level(input logic [31:0] pos, input logic [31:0] smp);
    return pos < smp;
  endfunction
endpackage

// File: rtl/fpwm_fifo.sv
module fpwm_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop_req,
  output logic [DW-1:0]    dout,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             empty
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop_req && !flush) |=> (count == CNT_W'(DEPTH)));

  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push && !flush) |=> empty);

  p_swap_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop_req && !flush) |=> full);
endmodule

// File: rtl/fpwm_core.sv
module fpwm_core
  import fpwm_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int PER_W = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PRE_W-1:0] presc,
  input  logic [PER_W-1:0] period,
  input  logic             smp_avail,
  input  logic [SMP_W-1:0] smp_in,
  output logic             take,
  output logic             period_start,
  output logic [SMP_W-1:0] active_smp,
  output logic             pwm_o
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PER_W:0]   cnt;
  logic [PER_W:0]   last;
  logic             started;
  logic             tick;

  assign tick         = en && (pre_cnt == presc);
  assign last         = (PER_W + 1)'(fpwm_last_tick(32'(period)));
  assign period_start = tick && (!started || (cnt >= last));
  assign take         = period_start && smp_avail;
  assign pwm_o        = started && fpwm_level(32'(cnt), 32'(active_smp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt    <= '0;
      cnt        <= '0;
      started    <= 1'b0;
      active_smp <= '0;
    end else if (clr) begin
      pre_cnt    <= '0;
      cnt        <= '0;
      started    <= 1'b0;
      active_smp <= '0;
    end else if (!en) begin
      pre_cnt <= '0;
      cnt     <= '0;
      started <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (period_start) begin
        cnt     <= '0;
        started <= 1'b1;
        if (take) active_smp <= smp_in;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_o);

  p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (started && active_smp == '0) |-> !pwm_o);

  p_start_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && !clr) |=> (pwm_o == (active_smp != '0)));

  p_keep_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && !take && !clr) |=> $stable(active_smp));
endmodule

// File: rtl/fpwm_regs.sv
module fpwm_regs
  import fpwm_pkg::*;
#(
  parameter int AW         = 5,
  parameter int SMP_W      = 16,
  parameter int PER_W      = 16,
  parameter int PRE_W      = 12,
  parameter int CNT_W      = 3,
  parameter int SWR_CYCLES = 4,
  localparam int SWR_W     = $clog2(SWR_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         reg_addr,
  input  logic                  reg_we,
  input  logic [31:0]           reg_wdata,
  input  logic [CNT_W-1:0]      fifo_count,
  input  logic                  push_ok,
  input  logic [SMP_W-1:0]      active_smp,
  output logic                  en,
  output logic [PRE_W-1:0]      presc,
  output logic [FPWM_CLK_W-1:0] clksrc,
  output logic [PER_W-1:0]      period,
  output logic                  smp_push,
  output logic [SMP_W-1:0]      smp_data,
  output logic                  swr_start,
  output logic                  swr_busy,
  output logic                  ovf,
  output logic [31:0]           reg_rdata
);
  logic [SWR_W-1:0] swr_cnt;
  logic             wr_ok;
  logic             hit_ctrl, hit_stat, hit_smp, hit_per;

  assign hit_ctrl  = (reg_addr == AW'(FPWM_A_CTRL));
  assign hit_stat  = (reg_addr == AW'(FPWM_A_STAT));
  assign hit_smp   = (reg_addr == AW'(FPWM_A_SAMPLE));
  assign hit_per   = (reg_addr == AW'(FPWM_A_PERIOD));

  assign swr_busy  = (swr_cnt != '0);
  assign wr_ok     = reg_we && !swr_busy;
  assign swr_start = wr_ok && hit_ctrl && reg_wdata[FPWM_SWR_BIT];
  assign smp_push  = wr_ok && hit_smp;
  assign smp_data  = reg_wdata[SMP_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      presc   <= '0;
      clksrc  <= '0;
      period  <= '0;
      ovf     <= 1'b0;
      swr_cnt <= '0;
    end else if (swr_start) begin
      en      <= 1'b0;
      presc   <= '0;
      clksrc  <= '0;
      period  <= '0;
      ovf     <= 1'b0;
      swr_cnt <= SWR_W'(SWR_CYCLES);
    end else begin
      if (swr_busy) swr_cnt <= swr_cnt - 1'b1;
      if (wr_ok && hit_ctrl) begin
        en     <= reg_wdata[FPWM_EN_BIT];
        presc  <= reg_wdata[FPWM_PRE_LSB +: PRE_W];
        clksrc <= reg_wdata[FPWM_CLK_LSB +: FPWM_CLK_W];
      end
      if (wr_ok && hit_per) period <= reg_wdata[PER_W-1:0];
      if (wr_ok && hit_stat && reg_wdata[FPWM_OVF_BIT]) ovf <= 1'b0;
      if (smp_push && !push_ok) ovf <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) begin
      reg_rdata[FPWM_EN_BIT]                    = en;
      reg_rdata[FPWM_SWR_BIT]                   = swr_busy;
      reg_rdata[FPWM_PRE_LSB +: PRE_W]          = presc;
      reg_rdata[FPWM_CLK_LSB +: FPWM_CLK_W]     = clksrc;
    end else if (hit_stat) begin
      reg_rdata[CNT_W-1:0]                      = fifo_count;
      reg_rdata[FPWM_OVF_BIT]                   = ovf;
    end else if (hit_smp) begin
      reg_rdata[SMP_W-1:0]                      = active_smp;
    end else if (hit_per) begin
      reg_rdata[PER_W-1:0]                      = period;
    end
  end

  p_swr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |-> (!en && presc == '0 && period == '0 && clksrc == '0));

  p_swr_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swr_start |=> (swr_busy && !ovf));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !swr_start && !(wr_ok && hit_stat && reg_wdata[FPWM_OVF_BIT])) |=> ovf);

  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(smp_push && !push_ok));
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
  import fpwm_pkg::*;
#(
  parameter int AW         = 5,
  parameter int DEPTH      = 4,
  parameter int SMP_W      = 16,
  parameter int PER_W      = 16,
  parameter int PRE_W      = 12,
  parameter int SWR_CYCLES = 4,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          pwm_o
);
  logic                  en, swr_start, swr_busy, ovf;
  logic [PRE_W-1:0]      presc;
  logic [FPWM_CLK_W-1:0] clksrc;
  logic [PER_W-1:0]      period;
  logic                  smp_push, push_ok, pop_ok, fifo_empty;
  logic [SMP_W-1:0]      smp_data, fifo_dout, active_smp;
  logic [CNT_W-1:0]      fifo_count;
  logic                  take, period_start;

  fpwm_regs #(
    .AW(AW), .SMP_W(SMP_W), .PER_W(PER_W), .PRE_W(PRE_W),
    .CNT_W(CNT_W), .SWR_CYCLES(SWR_CYCLES)
  ) regs_i (
    .clk, .rst_n, .reg_addr, .reg_we, .reg_wdata,
    .fifo_count, .push_ok, .active_smp,
    .en, .presc, .clksrc, .period, .smp_push, .smp_data,
    .swr_start, .swr_busy, .ovf, .reg_rdata
  );

  fpwm_fifo #(.DEPTH(DEPTH), .DW(SMP_W)) fifo_i (
    .clk, .rst_n, .flush(swr_start), .push(smp_push), .din(smp_data),
    .pop_req(take), .dout(fifo_dout), .count(fifo_count),
    .push_ok, .pop_ok, .empty(fifo_empty)
  );

  fpwm_core #(.SMP_W(SMP_W), .PER_W(PER_W), .PRE_W(PRE_W)) core_i (
    .clk, .rst_n, .clr(swr_start), .en, .presc, .period,
    .smp_avail(!fifo_empty), .smp_in(fifo_dout),
    .take, .period_start, .active_smp, .pwm_o
  );

  p_take_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> (period_start && en));

  p_swr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swr_busy |-> (!pwm_o && fifo_count == '0));
endmodule

// File: tb/fifo_pwm_tb_top.sv
module fifo_pwm_tb_top;
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_STAT = 5'h04;
  localparam logic [4:0] A_SMP  = 5'h0C;
  localparam logic [4:0] A_PER  = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fifo_pwm dut_i (
    .clk, .rst_n, .reg_addr, .reg_we, .reg_wdata, .reg_rdata, .pwm_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    reg_we = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hw_reset();
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_SMP,  v); chk("R1 sample", v, 0);
    rd(A_PER,  v); chk("R1 period", v, 0);
    chk("R1 pwm", 32'(pwm_o), 0);
  endtask

  task automatic t_fifo_fill();
    logic [31:0] v;
    hw_reset();
    for (int i = 1; i <= 4; i++) begin
      wr(A_SMP, 32'(i * 3));
      rd(A_STAT, v); chk("R2 occupancy", v, 32'(i));
    end
    wr(A_SMP, 32'd99);
    rd(A_STAT, v); chk("R3 drop sets flag", v, 32'h14);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R3 write 0 keeps flag", v, 32'h14);
    wr(A_STAT, 32'h10);
    rd(A_STAT, v); chk("R3 write 1 clears flag", v, 32'h04);
  endtask

  // period 3 -> 5 ticks; samples 2, 7 (beyond length), 0, then 0 repeated
  task automatic t_waveform();
    logic [31:0] v;
    int s;
    hw_reset();
    wr(A_PER, 32'd3);
    wr(A_SMP, 32'd2);
    wr(A_SMP, 32'd7);
    wr(A_SMP, 32'd0);
    wr(A_CTRL, 32'h0002_0001);
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      s = (i < 5) ? 2 : (i < 10) ? 7 : 0;
      chk($sformatf("R5 R4 wave step %0d", i), 32'(pwm_o), 32'((i % 5) < s));
    end
    rd(A_CTRL, v); chk("R9 clock source readback", v, 32'h0002_0001);
    rd(A_STAT, v); chk("R6 queue drained", v, 0);
    rd(A_SMP,  v); chk("R6 last sample held", v, 0);
  endtask

  // divide by 3, period 0 -> 2 ticks = 6 clocks, sample 1 -> 3 clocks high
  task automatic t_prescale();
    hw_reset();
    wr(A_PER, 32'd0);
    wr(A_SMP, 32'd1);
    wr(A_CTRL, 32'h0000_0021);
    @(negedge clk);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      chk($sformatf("R4 R6 prescaled step %0d", i), 32'(pwm_o),
          (i < 2) ? 32'd0 : 32'(((i - 2) % 6) < 3));
    end
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    hw_reset();
    wr(A_PER, 32'd9);
    for (int i = 0; i < 3; i++) wr(A_SMP, 32'd4);
    repeat (20) @(negedge clk);
    chk("R7 low while off", 32'(pwm_o), 0);
    rd(A_STAT, v); chk("R7 queue untouched", v, 3);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h0);
    repeat (30) @(negedge clk);
    chk("R7 low after disable", 32'(pwm_o), 0);
    rd(A_STAT, v); chk("R7 one sample used", v, 2);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    hw_reset();
    wr(A_PER, 32'd100);
    wr(A_SMP, 32'd11); wr(A_SMP, 32'd22); wr(A_SMP, 32'd33); wr(A_SMP, 32'd44);
    wr(A_CTRL, 32'h1);
    wr(A_SMP, 32'd55);
    rd(A_STAT, v); chk("R10 push on pop edge kept", v, 32'h04);
    rd(A_SMP, v);  chk("R6 first sample active", v, 32'd11);
    wr(A_SMP, 32'd66);
    rd(A_STAT, v); chk("R3 next push dropped", v, 32'h14);
    wr(A_PER, 32'd0);
    repeat (20) @(negedge clk);
    rd(A_SMP, v);  chk("R10 pushed value played", v, 32'd55);
    rd(A_STAT, v); chk("R6 queue empty flag kept", v, 32'h10);
  endtask

  task automatic t_swr_len();
    logic [31:0] v;
    hw_reset();
    wr(A_PER, 32'd7);
    wr(A_SMP, 32'd5);
    wr(A_CTRL, 32'h0001_0031);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h9);
    for (int i = 0; i < 5; i++) begin
      rd(A_CTRL, v);
      chk($sformatf("R8 reset bit clock %0d", i), v, (i < 4) ? 32'h8 : 32'h0);
    end
    rd(A_STAT, v); chk("R8 queue flushed", v, 0);
    rd(A_PER,  v); chk("R8 period cleared", v, 0);
    rd(A_SMP,  v); chk("R8 sample cleared", v, 0);
    chk("R8 output low", 32'(pwm_o), 0);
  endtask

  task automatic t_swr_ignore();
    logic [31:0] v;
    hw_reset();
    wr(A_CTRL, 32'h8);
    wr(A_PER, 32'd55);
    wr(A_SMP, 32'd3);
    repeat (6) @(negedge clk);
    rd(A_PER,  v); chk("R8 period write ignored", v, 0);
    rd(A_STAT, v); chk("R8 sample write ignored", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fifo_fill();
    t_waveform();
    t_prescale();
    t_disabled();
    t_same_cycle();
    t_swr_len();
    t_swr_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule